// File: doc/BRIEF.md
# Pulse-Stuff Command Latch with Single-Clock Inhibit

This block sits beside a time-division output multiplexer that serves a set of channels in turn. Once per minor frame, a strobe at the frame boundary samples a positive or a negative pulse-stuff request and holds it for the next frame. Each held command is available as an active-high enable and as an active-low copy. The active-low copies feed the address selection logic.

The block also drives one gated clock enable per channel. The enables come from a one-hot decode of the channel address currently being served. While a negative stuff is held, the block compares the served address with the overhead channel address during the word-29 timing window. On the first match it removes exactly one gated clock pulse, so the overhead channel loses one bit slot. A second match in the same window leaves the clock untouched. Such a match comes from a redundant address strapped to the same channel.

Top module: `stuff_clk_ctl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both held commands: `pos_en` and `neg_en` read 0, `pos_en_n` and `neg_en_n` read 1, and the inhibit guard is cleared.
- R2: At a clock edge with `frame_strobe` high, `pos_en` takes `pos_req & ~neg_req` and `neg_en` takes `neg_req & ~pos_req`. Without the strobe, both enables keep their values whatever the request inputs do.
- R3: When both requests are high at a strobe, both enables become 0. No stuff action is taken.
- R4: `pos_en_n` is always the inverse of `pos_en`, and `neg_en_n` is always the inverse of `neg_en`.
- R5: Whenever no inhibit is active, exactly one bit of `gclk_en` is high, and that bit is bit number `chan_addr`.
- R6: An inhibit forces every bit of `gclk_en` to 0 in the same cycle. It can occur only when `word29_win` is high, `neg_en` is 1 and `chan_addr` equals `ovh_addr`.
- R7: At most one inhibit cycle occurs per continuous high stretch of `word29_win`. Later address matches within that stretch produce the normal one-hot output.
- R8: Any cycle with `word29_win` low re-arms the guard, so the first match in the next window inhibits again.
- R9: While `word29_win` is low, an address match never inhibits, even with `neg_en` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Multiplexer clock |
| rst | input | 1 | Synchronous reset, active high |
| pos_req | input | 1 | Positive stuff request |
| neg_req | input | 1 | Negative stuff request |
| frame_strobe | input | 1 | Minor frame transition strobe, one cycle |
| word29_win | input | 1 | High for the cycles of word 29 |
| chan_addr | input | ADDR_W | Channel address currently served |
| ovh_addr | input | ADDR_W | Address of the channel receiving overhead service |
| pos_en | output | 1 | Held positive stuff enable |
| neg_en | output | 1 | Held negative stuff enable |
| pos_en_n | output | 1 | Active-low copy of pos_en |
| neg_en_n | output | 1 | Active-low copy of neg_en |
| gclk_en | output | 2**ADDR_W | One-hot gated clock enables, one per channel |

## Verification
The checker assumes `word29_win` is a contiguous level that falls for at least one cycle between windows. It also assumes `chan_addr` and `ovh_addr` are valid at every clock edge, because the guard re-arms only on a low window cycle. The stimulus follows these rules. Every window is preceded by a cycle with the window low. Addresses are driven just after an edge and stay steady until the next edge. Each window sweeps every channel address twice, which covers the redundant-match case against each overhead address in turn.

// File: rtl/stuff_pkg.sv
package stuff_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE = 2'b00,
      CMD_POS  = 2'b01,
      CMD_NEG  = 2'b10
   } stuff_cmd_e;

   // Conflicting or absent requests resolve to no action.
   function automatic stuff_cmd_e resolve_cmd(input logic pos, input logic neg);
      case ({neg, pos})
         2'b01:   return CMD_POS;
         2'b10:   return CMD_NEG;
         default: return CMD_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/stuff_cmd_latch.sv
module stuff_cmd_latch
   import stuff_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   input  logic pos_req,
   input  logic neg_req,
   output logic pos_en,
   output logic neg_en,
   output logic pos_en_n,
   output logic neg_en_n
);

   stuff_cmd_e cmd_q;

   always_ff @(posedge clk) begin
      if (rst)
         cmd_q <= CMD_IDLE;
      else if (strobe)
         cmd_q <= resolve_cmd(pos_req, neg_req);
   end

   assign pos_en   = (cmd_q == CMD_POS);
   assign neg_en   = (cmd_q == CMD_NEG);
   assign pos_en_n = ~pos_en;
   assign neg_en_n = ~neg_en;

endmodule

// File: rtl/stuff_match_oneshot.sv
module stuff_match_oneshot #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              win,
   input  logic              neg_en,
   input  logic [ADDR_W-1:0] chan_addr,
   input  logic [ADDR_W-1:0] ovh_addr,
   output logic              inhibit
);

   logic guard_q;
   logic addr_hit;

   // The comparator only counts inside the window.
   assign addr_hit = win && (chan_addr == ovh_addr);
   assign inhibit  = addr_hit && neg_en && !guard_q;

   always_ff @(posedge clk) begin
      if (rst || !win)
         guard_q <= 1'b0;
      else if (inhibit)
         guard_q <= 1'b1;
   end

endmodule

// File: rtl/stuff_clk_decoder.sv
module stuff_clk_decoder #(
   parameter int ADDR_W = 4,
   localparam int NUM_CH = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0] chan_addr,
   input  logic              inhibit,
   output logic [NUM_CH-1:0] gclk_en
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign gclk_en[i] = (chan_addr == ADDR_W'(i)) && !inhibit;
   end

endmodule

// File: rtl/stuff_clk_ctl.sv
module stuff_clk_ctl #(
   parameter int ADDR_W = 4,
   localparam int NUM_CH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pos_req,
   input  logic              neg_req,
   input  logic              frame_strobe,
   input  logic              word29_win,
   input  logic [ADDR_W-1:0] chan_addr,
   input  logic [ADDR_W-1:0] ovh_addr,
   output logic              pos_en,
   output logic              neg_en,
   output logic              pos_en_n,
   output logic              neg_en_n,
   output logic [NUM_CH-1:0] gclk_en
);

   if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_width
      $error("stuff_clk_ctl: ADDR_W must lie in 1..6");
   end

   logic inhibit;

   stuff_cmd_latch u_latch (
      .clk      (clk),
      .rst      (rst),
      .strobe   (frame_strobe),
      .pos_req  (pos_req),
      .neg_req  (neg_req),
      .pos_en   (pos_en),
      .neg_en   (neg_en),
      .pos_en_n (pos_en_n),
      .neg_en_n (neg_en_n)
   );

   stuff_match_oneshot #(.ADDR_W(ADDR_W)) u_oneshot (
      .clk       (clk),
      .rst       (rst),
      .win       (word29_win),
      .neg_en    (neg_en),
      .chan_addr (chan_addr),
      .ovh_addr  (ovh_addr),
      .inhibit   (inhibit)
   );

   stuff_clk_decoder #(.ADDR_W(ADDR_W)) u_dec (
      .chan_addr (chan_addr),
      .inhibit   (inhibit),
      .gclk_en   (gclk_en)
   );

endmodule

// File: rtl/stuff_clk_ctl_chk.sv
module stuff_clk_ctl_chk #(
   parameter int ADDR_W = 4
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     pos_req,
   input logic                     neg_req,
   input logic                     frame_strobe,
   input logic                     word29_win,
   input logic [ADDR_W-1:0]        chan_addr,
   input logic [ADDR_W-1:0]        ovh_addr,
   input logic                     pos_en,
   input logic                     neg_en,
   input logic                     pos_en_n,
   input logic                     neg_en_n,
   input logic [(1<<ADDR_W)-1:0]   gclk_en
);

   // Tracks whether a dropped clock was already seen in this window.
   logic dropped_q;

   always_ff @(posedge clk) begin
      if (rst || !word29_win)
         dropped_q <= 1'b0;
      else if (gclk_en == '0)
         dropped_q <= 1'b1;
   end

   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
      !frame_strobe |=> $stable({pos_en, neg_en})); // R2

   AST_BOTH_CANCEL: assert property (@(posedge clk) disable iff (rst)
      frame_strobe && pos_req && neg_req |=> !pos_en && !neg_en); // R3

   AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
      (pos_en_n != pos_en) && (neg_en_n != neg_en)); // R4

   AST_ONEHOT_SEL: assert property (@(posedge clk) disable iff (rst)
      gclk_en != '0 |-> $countones(gclk_en) == 1 && gclk_en[chan_addr]); // R5

   AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
      gclk_en == '0 |-> word29_win && neg_en && chan_addr == ovh_addr); // R6

   AST_SINGLE_DROP: assert property (@(posedge clk) disable iff (rst)
      word29_win && dropped_q |-> gclk_en != '0); // R7

   AST_NO_DROP_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
      !word29_win |-> gclk_en != '0); // R9

endmodule

bind stuff_clk_ctl stuff_clk_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/stuff_clk_ctl_test.sv
module stuff_clk_ctl_test;

   localparam int AW  = 4;
   localparam int NCH = 1 << AW;

   logic           clk;
   logic           rst;
   logic           pos_req;
   logic           neg_req;
   logic           frame_strobe;
   logic           word29_win;
   logic [AW-1:0]  chan_addr;
   logic [AW-1:0]  ovh_addr;
   logic           pos_en;
   logic           neg_en;
   logic           pos_en_n;
   logic           neg_en_n;
   logic [NCH-1:0] gclk_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   stuff_clk_ctl #(.ADDR_W(AW)) uut (
      .clk          (clk),
      .rst          (rst),
      .pos_req      (pos_req),
      .neg_req      (neg_req),
      .frame_strobe (frame_strobe),
      .word29_win   (word29_win),
      .chan_addr    (chan_addr),
      .ovh_addr     (ovh_addr),
      .pos_en       (pos_en),
      .neg_en       (neg_en),
      .pos_en_n     (pos_en_n),
      .neg_en_n     (neg_en_n),
      .gclk_en      (gclk_en)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check_enables(input string req, input logic p, input logic n);
      check(req, {28'd0, pos_en, neg_en, pos_en_n, neg_en_n}, {28'd0, p, n, ~p, ~n});
   endtask

   task automatic load_cmd(input logic p, input logic n);
      frame_strobe = 1'b1;
      pos_req = p;
      neg_req = n;
      tick();
      frame_strobe = 1'b0;
      pos_req = 1'b0;
      neg_req = 1'b0;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      rst = 1'b1;
      pos_req = 1'b0;
      neg_req = 1'b0;
      frame_strobe = 1'b0;
      word29_win = 1'b0;
      chan_addr = '0;
      ovh_addr = '0;
      repeat (3) tick();
      check_enables("R1", 1'b0, 1'b0);
      rst = 1'b0;
      tick();

      // R2 R3 R4: every request pair at a strobe, then a hold test
      for (int k = 0; k < 4; k++) begin
         logic p, n;
         p = k[0];
         n = k[1];
         load_cmd(p, n);
         check_enables((p && n) ? "R3" : "R2", p & ~n, n & ~p);
         check("R4", {30'd0, pos_en_n ^ pos_en, neg_en_n ^ neg_en}, 32'd3);
         pos_req = ~p;
         neg_req = ~n;
         tick();
         tick();
         check_enables("R2", p & ~n, n & ~p);
         pos_req = 1'b0;
         neg_req = 1'b0;
      end

      // Hold a negative stuff
      load_cmd(1'b0, 1'b1);
      check_enables("R2", 1'b0, 1'b1);

      // R9 R5: matches outside the window never drop a clock
      word29_win = 1'b0;
      for (int a = 0; a < NCH; a++) begin
         chan_addr = AW'(a);
         ovh_addr  = AW'(a);
         #1;
         check("R9", 32'(gclk_en), 32'(1) << a);
         tick();
      end

      // R6 R7 R8: each overhead address, two address sweeps per window
      for (int o = 0; o < NCH; o++) begin
         bit fired;
         word29_win = 1'b0;
         tick();
         ovh_addr = AW'(o);
         word29_win = 1'b1;
         fired = 0;
         for (int pass = 0; pass < 2; pass++) begin
            for (int c = 0; c < NCH; c++) begin
               logic [31:0] exp;
               chan_addr = AW'(c);
               #1;
               exp = (!fired && c == o) ? 32'd0 : (32'(1) << c);
               if (c == o && pass == 1)
                  check("R7", 32'(gclk_en), exp);
               else if (c == o)
                  check("R8", 32'(gclk_en), exp);
               else
                  check("R5", 32'(gclk_en), exp);
               if (c == o) fired = 1;
               tick();
            end
         end
      end
      word29_win = 1'b0;
      tick();

      // R6: with positive stuff held, matches in the window do not drop
      load_cmd(1'b1, 1'b0);
      check_enables("R2", 1'b1, 1'b0);
      word29_win = 1'b1;
      ovh_addr = 4'd9;
      for (int c = 0; c < NCH; c++) begin
         chan_addr = AW'(c);
         #1;
         check("R6", 32'(gclk_en), 32'(1) << c);
         tick();
      end
      word29_win = 1'b0;
      tick();

      // R1: reset mid-run clears a held negative stuff and the guard
      load_cmd(1'b0, 1'b1);
      rst = 1'b1;
      tick();
      check_enables("R1", 1'b0, 1'b0);
      rst = 1'b0;
      word29_win = 1'b1;
      chan_addr = 4'd9;
      #1;
      check("R1", 32'(gclk_en), 32'(1) << 9);
      tick();
      word29_win = 1'b0;
      tick();

      done = 1;
      report();
   end

endmodule